// File: doc/BRIEF.md
# Baud-Framed Serial Control Word Receiver

This block sits on the line-interface side of a symmetric DSL front end. Once per symbol period it takes a 16-bit control word from a DSP over three wires: a baud clock, an oversampling clock that runs at 48 times the symbol rate, and a serial data line. The oversampling clock is the block clock. The baud clock is brought into that domain through a synchronizer, and each rising transition of the baud clock starts a new frame of 48 slots. The word arrives MSB first in slots 1 to 16. Slots 17 to 48 carry nothing the block uses.

As soon as the last bit of the word has been sampled, the block decodes the word. It hands a signed 2B1Q symbol level to the pulse former, together with the receive gain, loopback and transmit boost settings. Symbols are delivered at the fixed baud rate, so the output has a valid pulse but no ready input, and the pulse former cannot apply back-pressure. It must take every symbol in the cycle in which `sym_valid` is high.

Two sticky flags report faults: `gain_code_err` for reserved gain codes, and `frame_err` for a baud edge that arrives before a frame has run its course.

Top module: `ctlword_rx`

## Requirements
- R1: During reset and after it, until the first word completes, `sym_level`, `gain_db`, `loopback`, `tx_boost`, `sym_valid`, `gain_code_err` and `frame_err` are all 0.
- R2: The baud clock passes through SYNC_STAGES flops in the `clk` domain, and a rising transition of it restarts the frame at slot 1. Counting the first `clk` edge that samples the baud clock high as edge 1, word bit 15 is sampled on edge SYNC_STAGES+2 and bit 0 on edge SYNC_STAGES+17. Serial data in slots 17 to 48 is ignored.
- R3: `sym_valid` is high for exactly one cycle per completed word, starting on the clock edge that samples bit 0. `sym_level`, `gain_db`, `loopback` and `tx_boost` change only on that edge.
- R4: When bit 15 (the enable) is 0, `sym_level` is 0 whatever bits 14:13 hold.
- R5: When bit 15 is 1, bits 14:13 select the symbol. The map is 00 to -3, 01 to -1, 11 to +1 and 10 to +3. `sym_level` is 3-bit two's complement: -3=101, -1=111, 0=000, +1=001, +3=011.
- R6: Bits 12:10 set `gain_db`: code 000 gives 0, 001 gives 3, 010 gives 6, 011 gives 9, 100 gives 12.
- R7: Gain codes 101, 110 and 111 leave `gain_db` at its previous value and set `gain_code_err`. The flag stays set until reset. The other fields of that word still take effect.
- R8: Bit 9 drives `loopback` (1 means line input disconnected, hybrid input kept) and bit 8 drives `tx_boost` (1 means +0.5 dB). Bits 7:0 are ignored.
- R9: A baud rising transition seen while the frame is in slots 1 to 47 sets `frame_err`, which stays set until reset. The frame restarts at slot 1, and a word cut off before its bit 0 produces no `sym_valid`.
- R10: If no new baud transition comes, the frame stops at slot 48: no further `sym_valid` pulses and no output change, and the next baud edge starts a frame without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampling clock, 48 cycles per symbol |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_clk | input | 1 | Baud clock from the DSP, asynchronous to `clk` |
| ser_data | input | 1 | Serial control word, MSB first |
| sym_level | output | 3 | Signed symbol level for the pulse former |
| sym_valid | output | 1 | One-cycle strobe for a new symbol and new settings |
| gain_db | output | 4 | Receive gain in dB (0, 3, 6, 9, 12) |
| loopback | output | 1 | Loopback select |
| tx_boost | output | 1 | Transmit power boost select |
| gain_code_err | output | 1 | Sticky: a reserved gain code was received |
| frame_err | output | 1 | Sticky: a baud edge cut a frame short |

## Verification
The bench builds the block with its defaults: 48 slots per frame, a 16-bit window and two synchronizer stages. With these values a full frame takes only 48 cycles, so many frames fit in one run. Every symbol and gain code, including all three reserved codes, is driven, and random data is placed in the 32 idle slots and in the ignored low byte. The short frame length also leaves room for an aborted frame, which lands its restart inside the data window, and for a long stretch with no baud edge after a frame has ended.

// File: rtl/ctlrx_pkg.sv
package ctlrx_pkg;

  typedef logic signed [2:0] sym_t;

  localparam int CW_W       = 16;
  localparam int EN_POS     = 15;
  localparam int SYM_HI     = 14;
  localparam int SYM_LO     = 13;
  localparam int GAIN_HI    = 12;
  localparam int GAIN_LO    = 10;
  localparam int LOOP_POS   = 9;
  localparam int BOOST_POS  = 8;
  localparam int GAIN_MAXC  = 4;

  localparam sym_t LVL_NEG3 = 3'sb101;
  localparam sym_t LVL_NEG1 = 3'sb111;
  localparam sym_t LVL_ZERO = 3'sb000;
  localparam sym_t LVL_POS1 = 3'sb001;
  localparam sym_t LVL_POS3 = 3'sb011;

  // Gray-ordered level map with enable override
  function automatic sym_t map_level(input logic en, input logic [1:0] code);
    sym_t r;
    if (!en) r = LVL_ZERO;
    else begin
      unique case (code)
        2'b00:   r = LVL_NEG3;
        2'b01:   r = LVL_NEG1;
        2'b11:   r = LVL_POS1;
        default: r = LVL_POS3;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/ctlrx_baud_sync.sv
module ctlrx_baud_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic baud_in,
  output logic baud_rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain  <= '0;
      last_q <= 1'b0;
    end else begin
      chain  <= {chain[STAGES-2:0], baud_in};
      last_q <= chain[STAGES-1];
    end
  end

  assign baud_rise = chain[STAGES-1] & ~last_q;

  // R2
  rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_rise |=> !baud_rise);

endmodule

// File: rtl/ctlrx_slot_timer.sv
module ctlrx_slot_timer #(
  parameter int SLOTS  = 48,
  parameter int WINDOW = 16,
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             baud_rise,
  output logic [CNT_W-1:0] slot,
  output logic             take_bit,
  output logic             last_bit,
  output logic             frame_err
);
  localparam logic [CNT_W-1:0] FIRST = CNT_W'(1);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(SLOTS);
  localparam logic [CNT_W-1:0] WEND  = CNT_W'(WINDOW);

  logic running;
  assign running = (slot != '0) && (slot != LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      slot      <= '0;
      frame_err <= 1'b0;
    end else if (baud_rise) begin
      if (running) frame_err <= 1'b1;
      slot <= FIRST;
    end else if (running) begin
      slot <= slot + FIRST;
    end
  end

  assign take_bit = !baud_rise && (slot >= FIRST) && (slot <= WEND);
  assign last_bit = !baud_rise && (slot == WEND);

  // R2
  slot_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    baud_rise |=> slot == FIRST);
  // R9
  frame_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> frame_err);
  // R10
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slot == LAST && !baud_rise) |=> slot == LAST);
  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot <= LAST);

endmodule

// File: rtl/ctlrx_shifter.sv
module ctlrx_shifter #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take_bit,
  input  logic             sdata,
  output logic [WIDTH-1:0] word_now
);
  logic [WIDTH-2:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n)        shreg <= '0;
    else if (take_bit) shreg <= {shreg[WIDTH-3:0], sdata};
  end

  // word as it stands once the bit present now is shifted in
  assign word_now = {shreg, sdata};

endmodule

// File: rtl/ctlrx_decode.sv
module ctlrx_decode
  import ctlrx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [CW_W-1:0] word,
  output sym_t            sym_level,
  output logic            sym_valid,
  output logic [3:0]      gain_db,
  output logic            loopback,
  output logic            tx_boost,
  output logic            gain_code_err
);
  logic [2:0] gcode;
  logic       gcode_ok;
  assign gcode    = word[GAIN_HI:GAIN_LO];
  assign gcode_ok = (gcode <= 3'(GAIN_MAXC));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sym_level     <= LVL_ZERO;
      sym_valid     <= 1'b0;
      gain_db       <= '0;
      loopback      <= 1'b0;
      tx_boost      <= 1'b0;
      gain_code_err <= 1'b0;
    end else begin
      sym_valid <= load;
      if (load) begin
        sym_level <= map_level(word[EN_POS], word[SYM_HI:SYM_LO]);
        loopback  <= word[LOOP_POS];
        tx_boost  <= word[BOOST_POS];
        if (gcode_ok) gain_db <= 4'(gcode) * 4'd3;
        else          gain_code_err <= 1'b1;
      end
    end
  end

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sym_valid |=> !sym_valid);
  // R3
  settings_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(gain_db) && $stable(loopback) && $stable(tx_boost) && $stable(sym_level)));
  // R7
  gain_err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    gain_code_err |=> gain_code_err);
  // R6
  gain_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gain_db == 4'd0 || gain_db == 4'd3 || gain_db == 4'd6 || gain_db == 4'd9 || gain_db == 4'd12));
  // R7
  gain_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !gcode_ok) |=> $stable(gain_db));

endmodule

// File: rtl/ctlword_rx.sv
module ctlword_rx
  import ctlrx_pkg::*;
#(
  parameter int SLOTS       = 48,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       baud_clk,
  input  logic       ser_data,
  output logic [2:0] sym_level,
  output logic       sym_valid,
  output logic [3:0] gain_db,
  output logic       loopback,
  output logic       tx_boost,
  output logic       gain_code_err,
  output logic       frame_err
);
  localparam int CNT_W = $clog2(SLOTS + 1);

  logic             baud_rise;
  logic [CNT_W-1:0] slot;
  logic             take_bit;
  logic             last_bit;
  logic [CW_W-1:0]  word_now;
  sym_t             lvl;

  ctlrx_baud_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .baud_in(baud_clk), .baud_rise(baud_rise));

  ctlrx_slot_timer #(.SLOTS(SLOTS), .WINDOW(CW_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .baud_rise(baud_rise), .slot(slot),
    .take_bit(take_bit), .last_bit(last_bit), .frame_err(frame_err));

  ctlrx_shifter #(.WIDTH(CW_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .take_bit(take_bit), .sdata(ser_data),
    .word_now(word_now));

  ctlrx_decode u_dec (
    .clk(clk), .rst_n(rst_n), .load(last_bit), .word(word_now),
    .sym_level(lvl), .sym_valid(sym_valid), .gain_db(gain_db),
    .loopback(loopback), .tx_boost(tx_boost), .gain_code_err(gain_code_err));

  assign sym_level = lvl;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!sym_valid && !frame_err && !gain_code_err && gain_db == 4'd0));
  // R3
  valid_at_window_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sym_valid) |-> $past(slot) == CNT_W'(CW_W));

endmodule

// File: tb/test_ctlword_rx.sv
module test_ctlword_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic baud = 1'b0;
  logic sdat = 1'b0;
  logic [2:0] sym_level;
  logic sym_valid, loopback, tx_boost, gain_code_err, frame_err;
  logic [3:0] gain_db;

  always #2 clk = ~clk;

  ctlword_rx i_ctlword_rx (
    .clk(clk), .rst_n(rst_n), .baud_clk(baud), .ser_data(sdat),
    .sym_level(sym_level), .sym_valid(sym_valid), .gain_db(gain_db),
    .loopback(loopback), .tx_boost(tx_boost),
    .gain_code_err(gain_code_err), .frame_err(frame_err));

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  int exp_gain = 0;
  int exp_sym = 0;
  int exp_loop = 0;
  int exp_boost = 0;
  int exp_gerr = 0;
  int exp_ferr = 0;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int level_of(logic [15:0] w);
    if (!w[15]) return 0;
    case (w[14:13])
      2'b00: return -3;
      2'b01: return -1;
      2'b11: return 1;
      default: return 3;
    endcase
  endfunction

  function automatic int sv(logic [2:0] s);
    return int'($signed(s));
  endfunction

  // One full 48-slot frame starting at the current negedge
  task automatic send(logic [15:0] w);
    int stray = 0;
    baud = 1'b1;
    sdat = 1'($urandom);
    for (int i = 1; i <= 48; i++) begin
      @(posedge clk); @(negedge clk);
      if (i == 19) begin
        if (w[12:10] > 3'd4) exp_gerr = 1;      // R7
        else exp_gain = 3 * int'(w[12:10]);     // R6
        exp_sym = level_of(w);
        exp_loop = int'(w[9]);
        exp_boost = int'(w[8]);
        chk("R3 valid at bit0", int'(sym_valid), 1);
        chk("R5/R4 symbol", sv(sym_level), exp_sym);
        chk("R6 gain", int'(gain_db), exp_gain);
        chk("R8 loopback", int'(loopback), exp_loop);
        chk("R8 boost", int'(tx_boost), exp_boost);
        chk("R7 gain_err", int'(gain_code_err), exp_gerr);
        chk("R9 frame_err", int'(frame_err), exp_ferr);
      end else if (sym_valid) stray++;
      if (i >= 3 && i <= 18) sdat = w[18 - i];
      else sdat = 1'($urandom);
      if (i == 24) baud = 1'b0;
    end
    chk("R3 single valid per frame", stray, 0);
    chk("R2 idle slots ignored sym", sv(sym_level), exp_sym);
    chk("R2 idle slots ignored gain", int'(gain_db), exp_gain);
  endtask

  // Short frame: baud restarts after n cycles
  task automatic abort_frame(int n);
    int seen = 0;
    baud = 1'b1;
    for (int i = 1; i <= n; i++) begin
      @(posedge clk); @(negedge clk);
      if (sym_valid) seen++;
      sdat = 1'($urandom);
      if (i == n / 2) baud = 1'b0;
    end
    chk("R9 aborted word not delivered", seen, 0);
    exp_ferr = 1;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    chk("R1 reset sym", sv(sym_level), 0);
    chk("R1 reset valid", int'(sym_valid), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 post-reset gain", int'(gain_db), 0);
    chk("R1 post-reset flags", int'({frame_err, gain_code_err, loopback, tx_boost}), 0);

    // R4: enable low with every symbol code
    for (int s = 0; s < 4; s++) send({1'b0, 2'(s), 3'd1, 2'b01, 8'hA5});
    // R5, R6: every symbol with every legal gain code
    for (int g = 0; g <= 4; g++)
      for (int s = 0; s < 4; s++)
        send({1'b1, 2'(s), 3'(g), 2'(s), 8'($urandom)});
    // R8: loopback/boost combinations with ignored low byte toggling
    send({1'b1, 2'b10, 3'd2, 2'b10, 8'hFF});
    send({1'b1, 2'b10, 3'd2, 2'b01, 8'h00});
    // R10: no baud edge for a long stretch
    begin
      int stray = 0;
      for (int i = 0; i < 150; i++) begin
        @(posedge clk); @(negedge clk);
        sdat = 1'($urandom);
        if (sym_valid) stray++;
      end
      chk("R10 no valid without baud", stray, 0);
      chk("R10 outputs held", int'(tx_boost), 1);
      chk("R10 no frame_err after idle", int'(frame_err), 0);
    end
    send({1'b1, 2'b00, 3'd3, 2'b00, 8'h3C});
    // R7: reserved gain codes
    for (int g = 5; g <= 7; g++) send({1'b1, 2'b11, 3'(g), 2'b11, 8'h5A});
    // R9: baud edge lands inside the data window
    abort_frame(10);
    send({1'b1, 2'b01, 3'd4, 2'b00, 8'h81});
    chk("R9 frame_err sticky", int'(frame_err), 1);
    // random frames
    for (int k = 0; k < 40; k++) send(16'($urandom));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule